// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a freshly powered SDRAM device to its working state. A single start pulse captures a 32-bit timing configuration word and a 32-bit bank configuration word. From the timing word's latency code and speed-select bit, and from the bus-width bit of the bank word, the block computes the mode-register value. It then drives a 32-bit control word that switches the memory clock on with refresh forced off, and holds it there for a settling interval of 200 microseconds.

After the settling interval the block walks a fixed command list. The list is precharge-all, then eight auto-refresh commands, then a mode-register load. A NOP follows every command. Each entry is held for a programmable number of cycles. When the list is finished, the control word is rewritten for normal operation: the enable stays set, the command field is cleared and refresh is no longer forced off. A sticky done flag then rises.

The outputs are the control word itself, plus its command and mode fields and the enable, forced-refresh, busy and done flags, brought out as separate ports for a controller downstream.

Top module: `sdram_powerup_seq`

## Requirements
- R1: After synchronous reset, and until a start pulse, the control word is zero and the enable, forced-refresh, busy and done flags are all low.
- R2: The mode data is 0x40 for CAS latency 2 with bank bit 23 set (32-bit bus) and 0x60 for latency 3 with that bit set. With bit 23 clear (16-bit bus) it is half those values: 0x20 for latency 2 and 0x30 for latency 3.
- R3: The latency code is bits 1:0 of the timing word. Bit 12 set selects 100 MHz, where code 0 means CAS latency 2. Bit 12 clear selects 50 MHz, where code 1 means CAS latency 2. Every other case means latency 3.
- R4: While busy, the control word is the captured timing word ANDed with 0x8000F9FF, with bit 31 set, bits 15:14 set, the mode data at bits 22:16 and the command code at bits 10:9. The mode_data port mirrors bits 23:16 of the word.
- R5: For exactly CLK_MHZ*200 cycles after the start edge, the word carries command code 0 (NOP) and the forced-refresh flag is high.
- R6: The commands then follow in this order, with codes 0=NOP, 1=load mode, 2=auto-refresh, 3=precharge-all: precharge, NOP, eight pairs of (refresh, NOP), load mode, NOP.
- R7: Each command entry stays on the outputs for exactly GAP_CYCLES cycles (default 5).
- R8: After the last entry, the word becomes (captured timing word AND 0x8000F9FF) with bit 31 set. The forced-refresh and busy flags go low, and done rises and stays high until reset.
- R9: The configuration is captured on the start edge. A start pulse or a configuration change while busy or done has no effect on the outputs.
- R10: Asserting reset part-way through the sequence returns the block to the idle state of R1, and a later start runs the sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse, honoured only in idle |
| timing_cfg | input | 32 | Timing configuration word |
| bank_cfg | input | 32 | Bank configuration word (bit 23 = 32-bit bus) |
| timing_out | output | 32 | Control word presented to the memory controller |
| cmd | output | 2 | Current command code |
| mode_data | output | 8 | Mode field of the control word (bits 23:16) |
| sdram_en | output | 1 | Memory clock enable |
| refresh_off | output | 1 | Refresh forced off |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (sticky) |

## Verification
The hardest situation to reach from the ports is a start pulse or a configuration change in the middle of a sequence that is already running. The state it could corrupt is the captured configuration, and that only shows in the control word after a long settling interval. The bench sets the clock parameter to 1 MHz so that the whole sequence fits in a few hundred cycles. In one run it inverts both configuration inputs and pulses start partway through settling, then compares every cycle of the word against values computed from the original configuration up to and past done.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CMDS   = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_LMR  = 2'd1,
    CMD_AREF = 2'd2,
    CMD_PALL = 2'd3
  } sd_cmd_e;

  localparam logic [31:0] KEEP_MASK   = 32'h8000_F9FF;
  localparam logic [31:0] EN_FLAG     = 32'h8000_0000;
  localparam logic [31:0] REF_OFF     = 32'h0000_C000;
  localparam int          CMD_LSB     = 9;
  localparam int          MODE_LSB    = 16;
  localparam int          SPEED_BIT   = 12;
  localparam int          WIDE_BIT    = 23;

  // CAS latency 2 decision from latency code and speed select
  function automatic logic cas_is_two(input logic [31:0] tword);
    logic fast;
    logic [1:0] code;
    fast = tword[SPEED_BIT];
    code = tword[1:0];
    return fast ? (code == 2'd0) : (code == 2'd1);
  endfunction

  // mode-register data for given latency and bus width
  function automatic logic [7:0] mode_field(input logic cl2, input logic wide);
    logic [7:0] full;
    full = cl2 ? 8'h40 : 8'h60;
    return wide ? full : (full >> 1);
  endfunction

  // command at a given table position (len = total table entries)
  function automatic sd_cmd_e step_cmd(input int idx, input int len);
    if (idx == 0)            return CMD_PALL;
    else if (idx % 2 == 1)   return CMD_NOP;
    else if (idx == len - 2) return CMD_LMR;
    else                     return CMD_AREF;
  endfunction

  function automatic logic [31:0] init_word(input logic [31:0] cfg,
                                            input logic [7:0]  mode,
                                            input sd_cmd_e     c);
    return (cfg & KEEP_MASK) | EN_FLAG | REF_OFF |
           (32'(mode) << MODE_LSB) | (32'(c) << CMD_LSB);
  endfunction

  function automatic logic [31:0] run_word(input logic [31:0] cfg);
    return (cfg & KEEP_MASK) | EN_FLAG;
  endfunction

endpackage

// File: rtl/sdram_mode_calc.sv
module sdram_mode_calc
  import sdram_init_pkg::*;
(
  input  logic [31:0] timing_cfg,
  input  logic [31:0] bank_cfg,
  output logic        cas_two,
  output logic [7:0]  mode_val
);
  logic unused_bank_bits;

  assign cas_two          = cas_is_two(timing_cfg);
  assign mode_val         = mode_field(cas_two, bank_cfg[WIDE_BIT]);
  assign unused_bank_bits = ^{bank_cfg[31:WIDE_BIT+1], bank_cfg[WIDE_BIT-1:0]};
endmodule

// File: rtl/sdram_settle_timer.sv
module sdram_settle_timer #(
  parameter int WAIT_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= CNT_W'(WAIT_CYCLES - 1);
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_cmd_stepper.sv
module sdram_cmd_stepper
  import sdram_init_pkg::*;
#(
  parameter int NUM_REFRESH = 8,
  parameter int GAP_CYCLES  = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  logic    run,
  output sd_cmd_e cmd,
  output logic    last_step
);
  localparam int TABLE_LEN = 4 + 2 * NUM_REFRESH;
  localparam int IDX_W     = $clog2(TABLE_LEN);
  localparam int GAP_W     = $clog2(GAP_CYCLES + 1);

  logic [IDX_W-1:0] idx_q;
  logic [GAP_W-1:0] gap_q;
  logic             at_end;

  assign at_end    = (idx_q == IDX_W'(TABLE_LEN - 1));
  assign last_step = at_end && (gap_q == '0);
  assign cmd       = step_cmd(int'(idx_q), TABLE_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      gap_q <= '0;
    end else if (load) begin
      idx_q <= '0;
      gap_q <= GAP_W'(GAP_CYCLES - 1);
    end else if (run) begin
      if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end else if (!at_end) begin
        idx_q <= idx_q + 1'b1;
        gap_q <= GAP_W'(GAP_CYCLES - 1);
      end
    end
  end
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int SETTLE_US   = 200,
  parameter int GAP_CYCLES  = 5,
  parameter int NUM_REFRESH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] timing_cfg,
  input  logic [31:0] bank_cfg,
  output logic [31:0] timing_out,
  output logic [1:0]  cmd,
  output logic [7:0]  mode_data,
  output logic        sdram_en,
  output logic        refresh_off,
  output logic        busy,
  output logic        done
);
  localparam int WAIT_CYCLES = CLK_MHZ * SETTLE_US;

  seq_state_e  state_q, state_d;
  logic [31:0] tcfg_q;
  logic [7:0]  mode_q;
  logic [7:0]  mode_now;
  logic        cas_two_now;
  logic        timer_expired;
  logic        step_last;
  sd_cmd_e     step_code;

  // named event wires
  logic        launch;
  logic        settle_active;
  logic        cmds_active;
  logic        settle_end;
  logic        seq_finish;
  sd_cmd_e     cmd_now;

  assign settle_active = (state_q == ST_SETTLE);
  assign cmds_active   = (state_q == ST_CMDS);
  assign launch        = (state_q == ST_IDLE) && start;
  assign settle_end    = settle_active && timer_expired;
  assign seq_finish    = cmds_active && step_last;

  sdram_mode_calc u_mode (
    .timing_cfg (timing_cfg),
    .bank_cfg   (bank_cfg),
    .cas_two    (cas_two_now),
    .mode_val   (mode_now)
  );

  sdram_settle_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (launch),
    .run     (settle_active),
    .expired (timer_expired)
  );

  sdram_cmd_stepper #(
    .NUM_REFRESH (NUM_REFRESH),
    .GAP_CYCLES  (GAP_CYCLES)
  ) u_step (
    .clk       (clk),
    .rst       (rst),
    .load      (settle_end),
    .run       (cmds_active),
    .cmd       (step_code),
    .last_step (step_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start)      state_d = ST_SETTLE;
      ST_SETTLE: if (settle_end) state_d = ST_CMDS;
      ST_CMDS:   if (seq_finish) state_d = ST_DONE;
      ST_DONE:                   state_d = ST_DONE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tcfg_q  <= '0;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        tcfg_q <= timing_cfg;
        mode_q <= mode_now;
      end
    end
  end

  assign cmd_now = cmds_active ? step_code : CMD_NOP;

  always_comb begin
    unique case (state_q)
      ST_SETTLE, ST_CMDS: timing_out = init_word(tcfg_q, mode_q, cmd_now);
      ST_DONE:            timing_out = run_word(tcfg_q);
      default:            timing_out = '0;
    endcase
  end

  assign cmd         = cmd_now;
  assign mode_data   = timing_out[MODE_LSB +: 8];
  assign sdram_en    = (state_q != ST_IDLE);
  assign refresh_off = settle_active || cmds_active;
  assign busy        = settle_active || cmds_active;
  assign done        = (state_q == ST_DONE);
endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int GAP_CYCLES = 5
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        sdram_en,
  input logic        refresh_off,
  input logic        settle_active,
  input logic [1:0]  cmd,
  input logic [31:0] timing_out
);
  logic [31:0] prev_word_q;
  logic        prev_busy_q;
  logic [7:0]  hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_word_q <= '0;
      prev_busy_q <= 1'b0;
      hold_q      <= '0;
    end else begin
      prev_word_q <= timing_out;
      prev_busy_q <= busy;
      if (timing_out != prev_word_q) hold_q <= '0;
      else if (hold_q != 8'hFF)      hold_q <= hold_q + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (timing_out == 32'h0 && !sdram_en && !refresh_off));

  a_r4_refresh_forced: assert property (@(posedge clk) disable iff (rst)
    busy |-> (timing_out[15:14] == 2'b11 && timing_out[31] && refresh_off));

  a_r5_settle_nop: assert property (@(posedge clk) disable iff (rst)
    settle_active |-> (cmd == 2'd0 && timing_out[10:9] == 2'd0));

  a_r7_hold_gap: assert property (@(posedge clk) disable iff (rst)
    (busy && prev_busy_q && timing_out != prev_word_q) |-> (int'(hold_q) >= GAP_CYCLES - 1));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !busy && sdram_en));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && prev_busy_q) |-> (timing_out[8:0] == prev_word_q[8:0]));
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .done          (done),
  .sdram_en      (sdram_en),
  .refresh_off   (refresh_off),
  .settle_active (settle_active),
  .cmd           (cmd),
  .timing_out    (timing_out)
);

// File: tb/sdram_powerup_seq_tb.sv
module sdram_powerup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 1;
  localparam int GAP        = 5;
  localparam int NREF       = 8;
  localparam int W          = MHZ * 200;
  localparam int LEN        = 4 + 2 * NREF;
  localparam int TOTAL      = W + LEN * GAP;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] timing_cfg = '0;
  logic [31:0] bank_cfg = '0;
  logic [31:0] timing_out;
  logic [1:0]  cmd;
  logic [7:0]  mode_data;
  logic        sdram_en, refresh_off, busy, done;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_powerup_seq #(
    .CLK_MHZ(MHZ), .SETTLE_US(200), .GAP_CYCLES(GAP), .NUM_REFRESH(NREF)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .timing_cfg(timing_cfg), .bank_cfg(bank_cfg),
    .timing_out(timing_out), .cmd(cmd), .mode_data(mode_data), .sdram_en(sdram_en),
    .refresh_off(refresh_off), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // bench model of the command list
  function automatic logic [1:0] exp_cmd(input int i);
    if (i == 0)            return 2'd3;
    if (i % 2 == 1)        return 2'd0;
    if (i == LEN - 2)      return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [31:0] exp_busy_word(input logic [31:0] t, input logic [7:0] m,
                                                input logic [1:0] c);
    logic [31:0] w;
    w = t & 32'h8000_F9FF;
    w[31]    = 1'b1;
    w[15:14] = 2'b11;
    w[23:16] = m;
    w[10:9]  = c;
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 word", timing_out, 32'h0);
    chk("R1 flags", {28'h0, sdram_en, refresh_off, busy, done}, 32'h0);
    @(negedge clk);
    chk("R1 idle hold", {timing_out[31:1], busy}, 32'h0);
  endtask

  // full run, checked every cycle; disturb tests R9 mid-run
  task automatic t_run(input logic [31:0] t, input logic [31:0] b,
                       input logic [7:0] m, input bit disturb);
    logic [31:0] fin;
    do_reset();
    timing_cfg = t;
    bank_cfg   = b;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fin = (t & 32'h8000_F9FF) | 32'h8000_0000;
    for (int k = 0; k < TOTAL + 4; k++) begin
      if (k == 0) begin
        chk("R2/R3 mode_data", {24'h0, mode_data}, {24'h0, m});
        chk("R4 word", timing_out, exp_busy_word(t, m, 2'd0));
      end
      if (k < W) begin
        if (k == 0 || k == W - 1) begin
          chk("R5 settle word", timing_out, exp_busy_word(t, m, 2'd0));
          chk("R5 settle flags", {28'h0, sdram_en, refresh_off, busy, done}, 32'h0000_000E);
        end
      end else if (k < TOTAL) begin
        chk("R7 word hold", timing_out, exp_busy_word(t, m, exp_cmd((k - W) / GAP)));
        chk("R6 cmd", {30'h0, cmd}, {30'h0, exp_cmd((k - W) / GAP)});
      end else begin
        chk("R8 final word", timing_out, fin);
        chk("R8 final flags", {28'h0, sdram_en, refresh_off, busy, done}, 32'h0000_0009);
      end
      if (disturb && k == 40) begin
        timing_cfg = ~t;
        bank_cfg   = ~b;
        start      = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (disturb && k == 41) chk("R9 start while busy", timing_out, exp_busy_word(t, m, 2'd0));
      @(negedge clk);
    end
    timing_cfg = ~t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 start after done word", timing_out, fin);
    chk("R9 start after done flag", {31'h0, done}, 32'h1);
  endtask

  task automatic t_reset_midrun();
    do_reset();
    timing_cfg = 32'h0000_1001;
    bank_cfg   = 32'h0080_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W + 7) @(negedge clk);
    chk("R10 busy before reset", {31'h0, busy}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 word after reset", timing_out, 32'h0);
    chk("R10 flags after reset", {28'h0, sdram_en, refresh_off, busy, done}, 32'h0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // 100 MHz, code 1 -> latency 3, 32-bit bus -> 0x60
    chk("R10 restart word", timing_out, exp_busy_word(32'h0000_1001, 8'h60, 2'd0));
  endtask

  initial begin
    t_reset_state();
    t_run(32'h1234_D1A4, 32'h0080_0000, 8'h40, 1'b0); // R3 fast code0 -> CL2, wide
    t_run(32'h0000_1002, 32'h0000_0000, 8'h30, 1'b1); // R3 fast code2 -> CL3, narrow
    t_run(32'h7FFF_EFFD, 32'hFF7F_FFFF, 8'h20, 1'b0); // R3 slow code1 -> CL2, narrow
    t_run(32'h0000_0000, 32'h0080_0000, 8'h60, 1'b0); // R3 slow code0 -> CL3, wide
    t_reset_midrun();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule